// File: doc/BRIEF.md
# Aliased Partial-Width Register File

This block holds eight 32-bit general registers. Each register can be accessed as a whole 32-bit doubleword or as its low 16-bit word. The first four registers also offer two 8-bit views: bits 7:0 and bits 15:8. Every access names a register index and a size code. A write narrower than 32 bits merges into the register, so every bit outside the addressed lane keeps its value. A narrow read returns the addressed lane shifted down to bit 0, with zeros above it.

The block has one write port and two independent read ports. A write is registered at the rising clock edge. Reads are combinational and have no bypass, so a write is seen only from the following cycle. A high-byte access to registers 4 to 7 does not exist. On the write port it raises a flag and is dropped. On a read port it returns zero. Reset is synchronous and active-low, and it clears every register.

Top module: `alias_regfile`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every register is cleared to zero, and every view of every register then reads 0.
- R2: A write with size code 2'b11 (doubleword) replaces all 32 bits of register `wr_sel` with `wr_data`.
- R3: A write with size code 2'b10 (word) loads `wr_data[15:0]` into bits 15:0 of the register, and bits 31:16 keep their old value.
- R4: A write with size code 2'b00 (low byte) loads `wr_data[7:0]` into bits 7:0 of any of the eight registers, and bits 31:8 keep their old value.
- R5: A write with size code 2'b01 (high byte) to register 0 to 3 loads `wr_data[7:0]` into bits 15:8, and bits 31:16 and 7:0 keep their old value.
- R6: A high-byte write to register 4 to 7 drives `wr_bad` high in the same cycle while `wr_en` is high, and leaves every register unchanged. `wr_bad` is low in every other case.
- R7: Reads are zero-extended to 32 bits. Low byte returns bits 7:0. High byte returns bits 15:8 in bits 7:0. Word returns bits 15:0. Doubleword returns all 32 bits. A high-byte read of register 4 to 7 returns 0.
- R8: A write becomes visible on the read ports only after the clock edge that stores it. A read in the same cycle as the write returns the old contents.
- R9: A write changes only the register it selects. The two read ports return their own selections independently, in the same cycle.
- R10: While `wr_en` is low, no register changes, whatever the other write inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write request |
| wr_sel | input | 3 | Register index for the write |
| wr_size | input | 2 | Write size code |
| wr_data | input | 32 | Write data; narrow writes use the low bits |
| wr_bad | output | 1 | Current write request is an illegal high-byte access |
| ra_sel | input | 3 | Read port A register index |
| ra_size | input | 2 | Read port A size code |
| ra_data | output | 32 | Read port A zero-extended data |
| rb_sel | input | 3 | Read port B register index |
| rb_size | input | 2 | Read port B size code |
| rb_data | output | 32 | Read port B zero-extended data |

## Verification
The hardest case to reach is proving that a narrow write kept the bits it did not address. A read of the same width shows only the bits the write replaced, so the stale bits cannot be seen that way. Each register is therefore first filled with a distinct doubleword in every byte. After each narrow write, the register is read back both as a doubleword and through the narrow views. The illegal high-byte write is driven with data that would be visible if it landed. All eight registers are then read back in full.

// File: rtl/alias_rf_pkg.sv
// Package: shared view-size codes for the aliased register file.
// Assumes: the size code field is two bits wide; the encoding is fixed by the interface.
package alias_rf_pkg;

    typedef enum logic [1:0] {
        VW_BYTE_LO = 2'b00,
        VW_BYTE_HI = 2'b01,
        VW_WORD    = 2'b10,
        VW_DWORD   = 2'b11
    } view_size_e;

endpackage

// File: rtl/alias_rf_wdec.sv
// Module: write decoder. It turns a write request into per-register enables,
// a lane mask and the data placed in its lane.
// Assumes: narrow write data arrives in the low bits of wr_data.
//          The high-byte view exists only for indices below NUM_HI.
module alias_rf_wdec
    import alias_rf_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int XLEN     = 32,
    parameter int BYTE_W   = 8,
    parameter int WORD_W   = 16,
    parameter int NUM_HI   = 4,
    localparam int SEL_W   = $clog2(NUM_REGS)
) (
    input  logic                wr_en,
    input  logic [SEL_W-1:0]    wr_sel,
    input  logic [1:0]          wr_size,
    input  logic [XLEN-1:0]     wr_data,
    output logic [NUM_REGS-1:0] reg_we,
    output logic [XLEN-1:0]     lane_mask,
    output logic [XLEN-1:0]     lane_data,
    output logic                illegal
);

    localparam logic [SEL_W-1:0] HI_LIMIT = SEL_W'(NUM_HI);

    logic hi_missing;

    // Purpose: find a high-byte request aimed at a register without that view.
    always_comb begin
        hi_missing = (view_size_e'(wr_size) == VW_BYTE_HI) && (wr_sel >= HI_LIMIT);
        illegal    = wr_en && hi_missing;
    end

    // Purpose: build the lane mask and place the write data in its lane.
    always_comb begin
        unique case (view_size_e'(wr_size))
            VW_BYTE_LO: begin
                lane_mask = {{(XLEN-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};
                lane_data = {{(XLEN-BYTE_W){1'b0}}, wr_data[BYTE_W-1:0]};
            end
            VW_BYTE_HI: begin
                lane_mask = {{(XLEN-BYTE_W){1'b0}}, {BYTE_W{1'b1}}} << BYTE_W;
                lane_data = {{(XLEN-BYTE_W){1'b0}}, wr_data[BYTE_W-1:0]} << BYTE_W;
            end
            VW_WORD: begin
                lane_mask = {{(XLEN-WORD_W){1'b0}}, {WORD_W{1'b1}}};
                lane_data = {{(XLEN-WORD_W){1'b0}}, wr_data[WORD_W-1:0]};
            end
            default: begin
                lane_mask = {XLEN{1'b1}};
                lane_data = wr_data;
            end
        endcase
    end

    // Purpose: one-hot enable for the addressed register, held off when illegal.
    always_comb begin
        for (int i = 0; i < NUM_REGS; i++) begin
            reg_we[i] = wr_en && !hi_missing && (wr_sel == SEL_W'(i));
        end
    end

endmodule

// File: rtl/alias_rf_cell.sv
// Module: one register of the file. It merges masked write data into its contents.
// Assumes: the mask and data lanes agree, so data bits outside the mask are zero.
//          The reset is synchronous and active-low.
module alias_rf_cell #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [XLEN-1:0] lane_mask,
    input  logic [XLEN-1:0] lane_data,
    output logic [XLEN-1:0] q
);

    // Purpose: clear on reset, or replace only the masked lane on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (we) begin
            q <= (q & ~lane_mask) | (lane_data & lane_mask);
        end
    end

endmodule

// File: rtl/alias_rf_rview.sv
// Module: read view. It selects a register and extracts the requested lane, zero-extended.
// Assumes: a high-byte read of an index without that view returns zero.
//          The path is purely combinational, with no bypass.
module alias_rf_rview
    import alias_rf_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int XLEN     = 32,
    parameter int BYTE_W   = 8,
    parameter int WORD_W   = 16,
    parameter int NUM_HI   = 4,
    localparam int SEL_W   = $clog2(NUM_REGS)
) (
    input  logic [NUM_REGS-1:0][XLEN-1:0] regs,
    input  logic [SEL_W-1:0]              sel,
    input  logic [1:0]                    size,
    output logic [XLEN-1:0]               data
);

    localparam logic [SEL_W-1:0] HI_LIMIT = SEL_W'(NUM_HI);

    logic [XLEN-1:0] picked;

    // Purpose: pick the addressed register.
    always_comb begin
        picked = regs[sel];
    end

    // Purpose: extract the addressed lane and zero the bits above it.
    always_comb begin
        unique case (view_size_e'(size))
            VW_BYTE_LO: data = {{(XLEN-BYTE_W){1'b0}}, picked[BYTE_W-1:0]};
            VW_BYTE_HI: data = (sel < HI_LIMIT) ?
                               {{(XLEN-BYTE_W){1'b0}}, picked[2*BYTE_W-1:BYTE_W]} : '0;
            VW_WORD:    data = {{(XLEN-WORD_W){1'b0}}, picked[WORD_W-1:0]};
            default:    data = picked;
        endcase
    end

endmodule

// File: rtl/alias_regfile.sv
// Module: top of the aliased partial-width register file. It has one merging
// write port and two zero-extending read ports.
// Assumes: the write is registered and the reads are combinational with no bypass.
//          The reset is synchronous and active-low.
module alias_regfile
    import alias_rf_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int XLEN     = 32,
    parameter int BYTE_W   = 8,
    parameter int WORD_W   = 16,
    parameter int NUM_HI   = 4,
    parameter int NUM_RD   = 2,
    localparam int SEL_W   = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [1:0]       wr_size,
    input  logic [XLEN-1:0]  wr_data,
    output logic             wr_bad,
    input  logic [SEL_W-1:0] ra_sel,
    input  logic [1:0]       ra_size,
    output logic [XLEN-1:0]  ra_data,
    input  logic [SEL_W-1:0] rb_sel,
    input  logic [1:0]       rb_size,
    output logic [XLEN-1:0]  rb_data
);

    logic [NUM_REGS-1:0][XLEN-1:0] regs_q;
    logic [NUM_REGS-1:0]           reg_we;
    logic [XLEN-1:0]               lane_mask;
    logic [XLEN-1:0]               lane_data;
    logic [NUM_RD-1:0][SEL_W-1:0]  rd_sel;
    logic [NUM_RD-1:0][1:0]        rd_size;
    logic [NUM_RD-1:0][XLEN-1:0]   rd_data;

    alias_rf_wdec #(
        .NUM_REGS(NUM_REGS), .XLEN(XLEN), .BYTE_W(BYTE_W),
        .WORD_W(WORD_W), .NUM_HI(NUM_HI)
    ) u_wdec (
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_size   (wr_size),
        .wr_data   (wr_data),
        .reg_we    (reg_we),
        .lane_mask (lane_mask),
        .lane_data (lane_data),
        .illegal   (wr_bad)
    );

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_cell
        alias_rf_cell #(.XLEN(XLEN)) u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .we        (reg_we[g]),
            .lane_mask (lane_mask),
            .lane_data (lane_data),
            .q         (regs_q[g])
        );
    end

    // Purpose: gather the read port inputs into arrays for the port loop.
    always_comb begin
        rd_sel[0]  = ra_sel;
        rd_size[0] = ra_size;
        rd_sel[1]  = rb_sel;
        rd_size[1] = rb_size;
    end

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        alias_rf_rview #(
            .NUM_REGS(NUM_REGS), .XLEN(XLEN), .BYTE_W(BYTE_W),
            .WORD_W(WORD_W), .NUM_HI(NUM_HI)
        ) u_rview (
            .regs (regs_q),
            .sel  (rd_sel[p]),
            .size (rd_size[p]),
            .data (rd_data[p])
        );
    end

    // Purpose: drive the read data outputs.
    always_comb begin
        ra_data = rd_data[0];
        rb_data = rd_data[1];
    end

endmodule

// File: rtl/alias_regfile_chk.sv
// Module: assertion checker for alias_regfile. It is bound to every instance.
// Assumes: it sees the stored registers through the regs_q net of the top.
module alias_regfile_chk
    import alias_rf_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int XLEN     = 32,
    parameter int BYTE_W   = 8,
    parameter int WORD_W   = 16,
    localparam int SEL_W   = $clog2(NUM_REGS)
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          wr_en,
    input logic [SEL_W-1:0]              wr_sel,
    input logic [1:0]                    wr_size,
    input logic [XLEN-1:0]               wr_data,
    input logic                          wr_bad,
    input logic [1:0]                    ra_size,
    input logic [XLEN-1:0]               ra_data,
    input logic [1:0]                    rb_size,
    input logic [XLEN-1:0]               rb_data,
    input logic [NUM_REGS-1:0][XLEN-1:0] regs_q
);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> regs_q == '0); // R1

    AST_DWORD_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (wr_size == 2'b11) |=> regs_q[$past(wr_sel)] == $past(wr_data)); // R2

    AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (wr_size != 2'b11)
        |=> regs_q[$past(wr_sel)][XLEN-1:WORD_W] == $past(regs_q[wr_sel][XLEN-1:WORD_W])); // R3

    AST_BAD_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_bad |=> regs_q == $past(regs_q)); // R6

    AST_BAD_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        wr_bad |-> wr_en); // R6

    AST_RA_ZEXT_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (ra_size[1] == 1'b0) |-> ra_data[XLEN-1:BYTE_W] == '0); // R7

    AST_RB_ZEXT_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_size[1] == 1'b0) |-> rb_data[XLEN-1:BYTE_W] == '0); // R7

    AST_RA_ZEXT_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (ra_size == 2'b10) |-> ra_data[XLEN-1:WORD_W] == '0); // R7

    AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> regs_q == $past(regs_q)); // R10

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_other
        AST_OTHERS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && (wr_sel == SEL_W'(i))) |=> regs_q[i] == $past(regs_q[i])); // R9
    end

endmodule

bind alias_regfile alias_regfile_chk #(
    .NUM_REGS(NUM_REGS), .XLEN(XLEN), .BYTE_W(BYTE_W), .WORD_W(WORD_W)
) u_chk (.*);

// File: tb/test_alias_regfile.sv
// Bench: directed tests for alias_regfile. Each task drives one scenario and checks its results.
module test_alias_regfile;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [1:0]  wr_size = '0;
    logic [31:0] wr_data = '0;
    logic        wr_bad;
    logic [2:0]  ra_sel = '0;
    logic [1:0]  ra_size = 2'b11;
    logic [31:0] ra_data;
    logic [2:0]  rb_sel = '0;
    logic [1:0]  rb_size = 2'b11;
    logic [31:0] rb_data;

    int          total = 0;
    int          bad = 0;
    logic [31:0] model [8];

    always #2.5 clk = ~clk;

    alias_regfile i_alias_regfile (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_size(wr_size), .wr_data(wr_data), .wr_bad(wr_bad),
        .ra_sel(ra_sel), .ra_size(ra_size), .ra_data(ra_data),
        .rb_sel(rb_sel), .rb_size(rb_size), .rb_data(rb_data)
    );

    // Expected register after a legal write, from R2..R5.
    function automatic logic [31:0] merged(logic [31:0] old, logic [1:0] sz, logic [31:0] d);
        case (sz)
            2'b00:   return {old[31:8], d[7:0]};
            2'b01:   return {old[31:16], d[7:0], old[7:0]};
            2'b10:   return {old[31:16], d[15:0]};
            default: return d;
        endcase
    endfunction

    // Expected read result, from R7.
    function automatic logic [31:0] view(logic [31:0] v, logic [2:0] s, logic [1:0] sz);
        case (sz)
            2'b00:   return {24'h0, v[7:0]};
            2'b01:   return (s < 3'd4) ? {24'h0, v[15:8]} : 32'h0;
            2'b10:   return {16'h0, v[15:0]};
            default: return v;
        endcase
    endfunction

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(logic [2:0] s, logic [1:0] sz, logic [31:0] d);
        @(negedge clk);
        wr_sel = s; wr_size = sz; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        if (!(sz == 2'b01 && s >= 3'd4)) model[s] = merged(model[s], sz, d);
    endtask

    // Reads port A and port B; called just after a negative edge.
    task automatic rd2(logic [2:0] sa, logic [1:0] za, logic [2:0] sb, logic [1:0] zb,
                       output logic [31:0] da, output logic [31:0] db);
        ra_sel = sa; ra_size = za; rb_sel = sb; rb_size = zb;
        #1;
        da = ra_data; db = rb_data;
    endtask

    task automatic check_all(string req);
        logic [31:0] a, b;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            rd2(3'(i), 2'b11, 3'(7 - i), 2'b11, a, b);
            check(req, a, model[i]);
            check(req, b, model[7 - i]);
        end
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 8; i++) model[i] = '0;
    endtask

    task automatic t_reset;
        logic [31:0] a, b;
        do_reset();
        check_all("R1");
        @(negedge clk);
        rd2(3'd1, 2'b01, 3'd2, 2'b00, a, b);
        check("R1", a, 32'h0);
        check("R1", b, 32'h0);
    endtask

    task automatic t_fill;
        for (int i = 0; i < 8; i++) wr(3'(i), 2'b11, 32'h11111111 * (i + 1) ^ 32'hA5C3_0000);
        check_all("R2");
    endtask

    task automatic t_word;
        wr(3'd2, 2'b10, 32'hDEAD_BEEF);
        check_all("R3");
    endtask

    task automatic t_byte_lo;
        wr(3'd6, 2'b00, 32'hFFFF_FF5A);
        wr(3'd0, 2'b00, 32'h0000_0033);
        check_all("R4");
    endtask

    task automatic t_byte_hi;
        logic [31:0] a, b;
        wr(3'd1, 2'b01, 32'h1234_56C7);
        wr(3'd3, 2'b01, 32'h0000_0099);
        check_all("R5");
        @(negedge clk);
        rd2(3'd1, 2'b01, 3'd3, 2'b01, a, b);
        check("R5", a, 32'h0000_00C7);
        check("R5", b, 32'h0000_0099);
    endtask

    task automatic t_illegal;
        logic [31:0] a, b;
        @(negedge clk);
        wr_sel = 3'd5; wr_size = 2'b01; wr_data = 32'hFFFF_FFFF; wr_en = 1'b1;
        #1;
        check("R6", 32'(wr_bad), 32'h1);
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        check("R6", 32'(wr_bad), 32'h0);
        check_all("R6");
        @(negedge clk);
        rd2(3'd5, 2'b01, 3'd7, 2'b01, a, b);
        check("R7", a, 32'h0);
        check("R7", b, 32'h0);
        @(negedge clk);
        wr_sel = 3'd2; wr_size = 2'b01; wr_en = 1'b1;
        #1;
        check("R6", 32'(wr_bad), 32'h0);
        wr_en = 1'b0;
    endtask

    task automatic t_views;
        logic [31:0] a, b;
        for (int s = 0; s < 8; s++) begin
            for (int z = 0; z < 4; z++) begin
                @(negedge clk);
                rd2(3'(s), 2'(z), 3'(7 - s), 2'(3 - z), a, b);
                check("R7", a, view(model[s], 3'(s), 2'(z)));
                check("R9", b, view(model[7 - s], 3'(7 - s), 2'(3 - z)));
            end
        end
    endtask

    task automatic t_no_bypass;
        logic [31:0] a, b;
        @(negedge clk);
        wr_sel = 3'd4; wr_size = 2'b11; wr_data = 32'h0BAD_F00D; wr_en = 1'b1;
        rd2(3'd4, 2'b11, 3'd4, 2'b10, a, b);
        check("R8", a, model[4]);
        check("R8", b, view(model[4], 3'd4, 2'b10));
        @(negedge clk);
        wr_en = 1'b0;
        model[4] = 32'h0BAD_F00D;
        rd2(3'd4, 2'b11, 3'd4, 2'b10, a, b);
        check("R8", a, 32'h0BAD_F00D);
        check("R8", b, 32'h0000_F00D);
    endtask

    task automatic t_idle;
        @(negedge clk);
        wr_en = 1'b0;
        for (int i = 0; i < 8; i++) begin
            wr_sel = 3'(i); wr_size = 2'(i); wr_data = 32'hCAFE_0000 + 32'(i);
            @(negedge clk);
        end
        check_all("R10");
    endtask

    initial begin
        #1_000_000;
        bad++;
        total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) model[i] = '0;
        t_reset();
        t_fill();
        t_word();
        t_byte_lo();
        t_byte_hi();
        t_illegal();
        t_views();
        t_no_bypass();
        t_idle();
        t_reset();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule